// File: doc/BRIEF.md
# Sync Polarity Auto-Detect Conditioner

This block sits at the front of a video input port. It takes the raw horizontal sync, vertical sync, horizontal data-enable and vertical data-enable lines, and samples them on the input pixel clock only when the port clock-enable is high. From these it produces active-high sync and data-enable signals for the processing that follows.

Each sync line may arrive with either polarity, and software does not say which. A tracker per sync line measures the duty cycle of the line. It counts qualified samples spent high and spent low between successive rising edges of the raw line, and treats the shorter level as the pulse. It commits a polarity once two periods in a row give the same answer. A loss flag shows when a sync line has gone quiet for longer than a programmable number of qualified samples.

The data-enable lines carry no timing information that could reveal their polarity, so each one has a configuration bit that inverts it. A composite mode drives the combined enable from the horizontal line alone.

Top module: `sync_pol_conditioner`

## Requirements
- R1: On a cycle with `pix_en` low the block samples nothing. Every sync output, status flag and sampled data-enable level keeps its value into the next cycle.
- R2: For each sync line, a period runs from one qualified sample where the raw line rises (0 in the previous qualified sample, 1 now) to the qualified sample just before the next rise. The candidate polarity is active-high (status bit 1) when the period holds fewer high samples than low samples, and active-low (status bit 0) otherwise, so a tie gives active-low. Counts saturate at 2^CNT_W-1.
- R3: The lock flag of a sync line rises, and its polarity bit takes the candidate, only at a rise that ends a period whose candidate equals the candidate of the period just before. The first rise after reset or loss only starts measuring. Periods must be complete to count.
- R4: While a sync line is not locked, its normalised output is 0. Once it is locked, the output is 1 exactly when the last qualified sample equals the detected active level.
- R5: With `cfg_timeout` nonzero, a loss is raised at the qualified sample that completes `cfg_timeout` consecutive qualified samples without a level change. The loss also clears the lock and restarts detection from the next rise. The next level change clears the loss flag. A value of zero disables the timeout.
- R6: `hde_out` is the last qualified horizontal DE sample XOR `cfg_hde_invert`. Outside composite mode, `vde_out` is the last qualified vertical DE sample XOR `cfg_vde_invert`. Both configuration bits act at once.
- R7: With `cfg_composite_de` high, `vde_out` is 1 whatever the vertical DE input is. In every mode, `de_out` equals `hde_out` AND `vde_out`.
- R8: After reset, all outputs and status flags are 0 while `cfg_composite_de` and both invert bits are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Input pixel clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pix_en | input | 1 | Port clock-enable; qualifies every sample |
| hsync_in | input | 1 | Raw horizontal sync, unknown polarity |
| vsync_in | input | 1 | Raw vertical sync, unknown polarity |
| hde_in | input | 1 | Raw horizontal (or composite) data enable |
| vde_in | input | 1 | Raw vertical data enable |
| cfg_hde_invert | input | 1 | Invert horizontal DE |
| cfg_vde_invert | input | 1 | Invert vertical DE |
| cfg_composite_de | input | 1 | Composite DE mode: vertical DE taken as 1 |
| cfg_timeout | input | CNT_W | Edgeless qualified samples before loss; 0 disables |
| hsync_out | output | 1 | Normalised active-high horizontal sync |
| vsync_out | output | 1 | Normalised active-high vertical sync |
| hde_out | output | 1 | Normalised horizontal DE |
| vde_out | output | 1 | Normalised vertical DE |
| de_out | output | 1 | Combined data enable |
| hs_pol_locked | output | 1 | Horizontal sync polarity committed |
| hs_active_high | output | 1 | Detected horizontal sync polarity, 1 = active high |
| vs_pol_locked | output | 1 | Vertical sync polarity committed |
| vs_active_high | output | 1 | Detected vertical sync polarity, 1 = active high |
| hs_lost | output | 1 | Horizontal sync timeout |
| vs_lost | output | 1 | Vertical sync timeout |

## Verification
The properties assume the configuration inputs change only between clock edges and that `pix_en` is a clean level sampled at the edge. They make no assumption about sync duty cycles, because the lock, loss and stall properties hold for any waveform. The stimulus drives each raw sync line as a periodic pulse train of chosen period, width and inversion, with `pix_en` either always high or gated on two cycles in three. It also holds one sync line flat to provoke a timeout, includes an equal-duty case, and walks the invert and composite bits through all combinations while the data-enable lines toggle.

// File: rtl/spc_pkg.sv
package spc_pkg;
  localparam int NUM_SYNC = 2;
  localparam int CH_H = 0;
  localparam int CH_V = 1;

  typedef enum logic [1:0] {
    ST_SEEK    = 2'd0,
    ST_MEASURE = 2'd1,
    ST_CONFIRM = 2'd2
  } spc_stage_e;

  typedef struct packed {
    logic locked;
    logic active_high;
    logic lost;
  } spc_status_t;
endpackage

// File: rtl/spc_pol_tracker.sv
module spc_pol_tracker
  import spc_pkg::*;
#(
  parameter int CNT_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic             sync_raw,
  input  logic [CNT_W-1:0] timeout,
  output logic             level_q,
  output spc_status_t      status
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;
  localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

  logic [CNT_W-1:0] hi_cnt, lo_cnt, idle_cnt;
  logic [CNT_W-1:0] hi_inc, lo_inc, idle_inc;
  spc_stage_e       stage;
  logic             cand_q, locked_q, pol_q, lost_q;
  logic             rise, fall, level_change, cand_now, timed_out;

  assign rise         = sync_raw & ~level_q;
  assign fall         = ~sync_raw & level_q;
  assign level_change = rise | fall;
  assign hi_inc       = (hi_cnt == CNT_MAX) ? hi_cnt : hi_cnt + CNT_ONE;
  assign lo_inc       = (lo_cnt == CNT_MAX) ? lo_cnt : lo_cnt + CNT_ONE;
  assign idle_inc     = (idle_cnt == CNT_MAX) ? idle_cnt : idle_cnt + CNT_ONE;
  // shorter level is the pulse; a tie resolves to active-low
  assign cand_now     = (hi_cnt < lo_cnt);
  assign timed_out    = (timeout != '0) && !level_change && (idle_inc >= timeout);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      level_q  <= 1'b0;
      hi_cnt   <= '0;
      lo_cnt   <= '0;
      idle_cnt <= '0;
      stage    <= ST_SEEK;
      cand_q   <= 1'b0;
      locked_q <= 1'b0;
      pol_q    <= 1'b0;
      lost_q   <= 1'b0;
    end else if (en) begin
      level_q <= sync_raw;

      if (level_change) begin
        idle_cnt <= '0;
        lost_q   <= 1'b0;
      end else begin
        idle_cnt <= idle_inc;
      end

      if (rise) begin
        hi_cnt <= CNT_ONE;
        lo_cnt <= '0;
      end else if (sync_raw) begin
        hi_cnt <= hi_inc;
      end else begin
        lo_cnt <= lo_inc;
      end

      if (timed_out) begin
        lost_q   <= 1'b1;
        locked_q <= 1'b0;
        stage    <= ST_SEEK;
      end else if (rise) begin
        unique case (stage)
          ST_SEEK: stage <= ST_MEASURE;
          ST_MEASURE: begin
            cand_q <= cand_now;
            stage  <= ST_CONFIRM;
          end
          default: begin
            cand_q <= cand_now;
            if (cand_now == cand_q) begin
              locked_q <= 1'b1;
              pol_q    <= cand_now;
            end
          end
        endcase
      end
    end
  end

  assign status.locked      = locked_q;
  assign status.active_high = pol_q;
  assign status.lost        = lost_q;
endmodule

// File: rtl/spc_de_norm.sv
module spc_de_norm (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  input  logic hde_raw,
  input  logic vde_raw,
  input  logic hde_inv,
  input  logic vde_inv,
  input  logic composite,
  output logic hde_n,
  output logic vde_n,
  output logic de_n
);
  logic hde_q, vde_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hde_q <= 1'b0;
      vde_q <= 1'b0;
    end else if (en) begin
      hde_q <= hde_raw;
      vde_q <= vde_raw;
    end
  end

  assign hde_n = hde_q ^ hde_inv;
  assign vde_n = composite ? 1'b1 : (vde_q ^ vde_inv);
  assign de_n  = hde_n & vde_n;
endmodule

// File: rtl/sync_pol_conditioner.sv
module sync_pol_conditioner
  import spc_pkg::*;
#(
  parameter int CNT_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pix_en,
  input  logic             hsync_in,
  input  logic             vsync_in,
  input  logic             hde_in,
  input  logic             vde_in,
  input  logic             cfg_hde_invert,
  input  logic             cfg_vde_invert,
  input  logic             cfg_composite_de,
  input  logic [CNT_W-1:0] cfg_timeout,
  output logic             hsync_out,
  output logic             vsync_out,
  output logic             hde_out,
  output logic             vde_out,
  output logic             de_out,
  output logic             hs_pol_locked,
  output logic             hs_active_high,
  output logic             vs_pol_locked,
  output logic             vs_active_high,
  output logic             hs_lost,
  output logic             vs_lost
);
  logic [NUM_SYNC-1:0] sync_raw, sync_level, sync_norm;
  spc_status_t         sync_stat [NUM_SYNC];

  assign sync_raw[CH_H] = hsync_in;
  assign sync_raw[CH_V] = vsync_in;

  for (genvar g = 0; g < NUM_SYNC; g++) begin : g_trk
    spc_pol_tracker #(.CNT_W(CNT_W)) u_trk (
      .clk      (clk),
      .rst_n    (rst_n),
      .en       (pix_en),
      .sync_raw (sync_raw[g]),
      .timeout  (cfg_timeout),
      .level_q  (sync_level[g]),
      .status   (sync_stat[g])
    );
    assign sync_norm[g] = sync_stat[g].locked &
                          (sync_level[g] == sync_stat[g].active_high);
  end

  spc_de_norm u_de (
    .clk       (clk),
    .rst_n     (rst_n),
    .en        (pix_en),
    .hde_raw   (hde_in),
    .vde_raw   (vde_in),
    .hde_inv   (cfg_hde_invert),
    .vde_inv   (cfg_vde_invert),
    .composite (cfg_composite_de),
    .hde_n     (hde_out),
    .vde_n     (vde_out),
    .de_n      (de_out)
  );

  assign hsync_out      = sync_norm[CH_H];
  assign vsync_out      = sync_norm[CH_V];
  assign hs_pol_locked  = sync_stat[CH_H].locked;
  assign hs_active_high = sync_stat[CH_H].active_high;
  assign hs_lost        = sync_stat[CH_H].lost;
  assign vs_pol_locked  = sync_stat[CH_V].locked;
  assign vs_active_high = sync_stat[CH_V].active_high;
  assign vs_lost        = sync_stat[CH_V].lost;
endmodule

// File: rtl/sync_pol_conditioner_chk.sv
module sync_pol_conditioner_chk #(
  parameter int CNT_W = 12
) (
  input logic             clk,
  input logic             rst_n,
  input logic             pix_en,
  input logic             hsync_in,
  input logic             vsync_in,
  input logic             hde_in,
  input logic             vde_in,
  input logic             cfg_hde_invert,
  input logic             cfg_vde_invert,
  input logic             cfg_composite_de,
  input logic [CNT_W-1:0] cfg_timeout,
  input logic             hsync_out,
  input logic             vsync_out,
  input logic             hde_out,
  input logic             vde_out,
  input logic             de_out,
  input logic             hs_pol_locked,
  input logic             hs_active_high,
  input logic             vs_pol_locked,
  input logic             vs_active_high,
  input logic             hs_lost,
  input logic             vs_lost
);
  p_hs_idle_unlocked_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !hs_pol_locked |-> !hsync_out);
  p_vs_idle_unlocked_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !vs_pol_locked |-> !vsync_out);
  p_hold_without_en_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !pix_en |=> ($stable(hsync_out) && $stable(vsync_out) &&
                 $stable(hs_pol_locked) && $stable(vs_pol_locked) &&
                 $stable(hs_active_high) && $stable(vs_active_high) &&
                 $stable(hs_lost) && $stable(vs_lost)));
  p_hs_lock_on_en_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(hs_pol_locked) |-> $past(pix_en));
  p_vs_lock_on_en_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(vs_pol_locked) |-> $past(pix_en));
  p_hs_lost_unlocks_r5: assert property (@(posedge clk) disable iff (!rst_n)
    hs_lost |-> !hs_pol_locked);
  p_vs_lost_unlocks_r5: assert property (@(posedge clk) disable iff (!rst_n)
    vs_lost |-> !vs_pol_locked);
  p_composite_vde_r7: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_composite_de |-> vde_out);
  p_de_gated_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !hde_out |-> !de_out);
endmodule

bind sync_pol_conditioner sync_pol_conditioner_chk #(.CNT_W(CNT_W)) u_chk (.*);

// File: tb/sync_pol_conditioner_bench.sv
module sync_pol_conditioner_bench;
  localparam int CLK_PER = 10;
  localparam int CNT_W   = 12;
  localparam int CMAX    = (1 << CNT_W) - 1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic pix_en = 1'b0;
  logic hsync_in = 1'b0, vsync_in = 1'b0, hde_in = 1'b0, vde_in = 1'b0;
  logic cfg_hde_invert = 1'b0, cfg_vde_invert = 1'b0, cfg_composite_de = 1'b0;
  logic [CNT_W-1:0] cfg_timeout = '0;
  logic hsync_out, vsync_out, hde_out, vde_out, de_out;
  logic hs_pol_locked, hs_active_high, vs_pol_locked, vs_active_high, hs_lost, vs_lost;

  always #(CLK_PER/2) clk = ~clk;

  sync_pol_conditioner #(.CNT_W(CNT_W)) u_sync_pol_conditioner (.*);

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  task automatic check(string tag, string what, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s actual=%0d expected=%0d at %0t", tag, what, act, exp, $time);
    end
  endtask

  // behavioural reference model, one entry per sync line (0 = H, 1 = V)
  int m_prev[2], m_hi[2], m_lo[2], m_idle[2], m_stage[2];
  int m_cand[2], m_lock[2], m_pol[2], m_lost[2];
  int m_hde, m_vde;

  task automatic model_clear();
    for (int c = 0; c < 2; c++) begin
      m_prev[c] = 0; m_hi[c] = 0; m_lo[c] = 0; m_idle[c] = 0; m_stage[c] = 0;
      m_cand[c] = 0; m_lock[c] = 0; m_pol[c] = 0; m_lost[c] = 0;
    end
    m_hde = 0; m_vde = 0;
  endtask

  task automatic model_sync(int c, int x);
    int cand;
    if (x != m_prev[c]) begin
      m_idle[c] = 0;
      m_lost[c] = 0;
      if (x == 1) begin
        cand = (m_hi[c] < m_lo[c]) ? 1 : 0;
        if (m_stage[c] == 1) begin m_cand[c] = cand; m_stage[c] = 2; end
        else if (m_stage[c] == 2) begin
          if (cand == m_cand[c]) begin m_lock[c] = 1; m_pol[c] = cand; end
          m_cand[c] = cand;
        end else m_stage[c] = 1;
        m_hi[c] = 1; m_lo[c] = 0;
      end else if (m_lo[c] < CMAX) m_lo[c]++;
    end else begin
      if (x == 1) begin if (m_hi[c] < CMAX) m_hi[c]++; end
      else if (m_lo[c] < CMAX) m_lo[c]++;
      if (m_idle[c] < CMAX) m_idle[c]++;
      if (cfg_timeout != 0 && m_idle[c] >= int'(cfg_timeout)) begin
        m_lost[c] = 1; m_lock[c] = 0; m_stage[c] = 0;
      end
    end
    m_prev[c] = x;
  endtask

  initial model_clear();
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) model_clear();
    else if (pix_en) begin
      model_sync(0, int'(hsync_in));
      model_sync(1, int'(vsync_in));
      m_hde = int'(hde_in);
      m_vde = int'(vde_in);
    end
  end

  // per-cycle comparison, a quarter period after the active edge
  always @(posedge clk) begin
    int eh, ev, ehde, evde;
    #(CLK_PER/4);
    if (rst_n && !done) begin
      eh   = (m_lock[0] != 0 && m_prev[0] == m_pol[0]) ? 1 : 0;
      ev   = (m_lock[1] != 0 && m_prev[1] == m_pol[1]) ? 1 : 0;
      ehde = m_hde ^ int'(cfg_hde_invert);
      evde = cfg_composite_de ? 1 : (m_vde ^ int'(cfg_vde_invert));
      check("R4", "hsync_out", int'(hsync_out), eh);
      check("R4", "vsync_out", int'(vsync_out), ev);
      check("R3", "hs_pol_locked", int'(hs_pol_locked), m_lock[0]);
      check("R3", "vs_pol_locked", int'(vs_pol_locked), m_lock[1]);
      check("R2", "hs_active_high", int'(hs_active_high), m_pol[0]);
      check("R2", "vs_active_high", int'(vs_active_high), m_pol[1]);
      check("R5", "hs_lost", int'(hs_lost), m_lost[0]);
      check("R5", "vs_lost", int'(vs_lost), m_lost[1]);
      check("R6", "hde_out", int'(hde_out), ehde);
      check("R7", "vde_out", int'(vde_out), evde);
      check("R7", "de_out", int'(de_out), ehde & evde);
    end
  end

  // stimulus pattern
  int cyc = 0;
  int h_per = 20, h_hi = 17, h_inv = 0, h_hold = 0;
  int v_per = 200, v_hi = 6, v_inv = 0;
  int en_mode = 0;
  int cfg_walk = 1;

  task automatic run(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      cyc++;
      pix_en   = (en_mode == 0) ? 1'b1 : ((cyc % 3) != 0);
      if (!h_hold) hsync_in = (((cyc % h_per) < h_hi) ? 1'b1 : 1'b0) ^ h_inv[0];
      vsync_in = (((cyc % v_per) < v_hi) ? 1'b1 : 1'b0) ^ v_inv[0];
      hde_in   = ((cyc % 7) < 4);
      vde_in   = ((cyc % 11) < 8);
      if (cfg_walk) begin
        cfg_hde_invert   = cyc[6];
        cfg_vde_invert   = cyc[7];
        cfg_composite_de = cyc[8];
      end
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R8: reset state
    check("R8", "hsync_out", int'(hsync_out), 0);
    check("R8", "vsync_out", int'(vsync_out), 0);
    check("R8", "locks", int'(hs_pol_locked | vs_pol_locked), 0);
    check("R8", "lost", int'(hs_lost | vs_lost), 0);
    check("R8", "de_out", int'(de_out | hde_out | vde_out), 0);
    rst_n = 1'b1;
    cfg_timeout = 12'd300;

    // R2/R3: short low pulse on H, short high pulse on V, enable always high
    run(1000);
    check("R3", "hs locked after steady periods", int'(hs_pol_locked), 1);
    check("R2", "hs detected active-low", int'(hs_active_high), 0);
    check("R3", "vs locked after steady periods", int'(vs_pol_locked), 1);
    check("R2", "vs detected active-high", int'(vs_active_high), 1);

    // swap polarities, gated enable
    h_per = 24; h_hi = 4; v_per = 300; v_hi = 290; en_mode = 1;
    run(1800);
    check("R2", "hs now active-high", int'(hs_active_high), 1);
    check("R2", "vs now active-low", int'(vs_active_high), 0);

    // R2 tie: equal duty resolves to active-low
    en_mode = 0; h_per = 20; h_hi = 10;
    run(200);
    check("R2", "tie gives active-low", int'(hs_active_high), 0);
    check("R3", "tie still locks", int'(hs_pol_locked), 1);

    // R1: clock-enable low, inputs toggling, nothing moves
    begin
      int s_h, s_v, s_l, s_de;
      cfg_walk = 0;
      run(1);
      s_h = int'(hsync_out); s_v = int'(vsync_out);
      s_l = int'({hs_pol_locked, vs_pol_locked, hs_active_high, vs_active_high});
      s_de = int'({hde_out, vde_out, de_out});
      for (int i = 0; i < 25; i++) begin
        @(negedge clk);
        pix_en = 1'b0;
        hsync_in = ~hsync_in; vsync_in = ~vsync_in;
        hde_in = ~hde_in; vde_in = ~vde_in;
        #(CLK_PER/4);
        check("R1", "hsync_out held", int'(hsync_out), s_h);
        check("R1", "vsync_out held", int'(vsync_out), s_v);
        check("R1", "status held",
              int'({hs_pol_locked, vs_pol_locked, hs_active_high, vs_active_high}), s_l);
        check("R1", "DE held", int'({hde_out, vde_out, de_out}), s_de);
      end
      cfg_walk = 1;
    end

    // R5: H line stalls with a short timeout
    cfg_timeout = 12'd50; v_per = 40; v_hi = 4; h_hold = 1;
    run(120);
    check("R5", "hs_lost raised", int'(hs_lost), 1);
    check("R5", "hs unlocked on loss", int'(hs_pol_locked), 0);
    check("R4", "hsync_out idle while lost", int'(hsync_out), 0);
    check("R5", "vs not lost", int'(vs_lost), 0);
    h_hold = 0; h_per = 30; h_hi = 3;
    run(200);
    check("R5", "hs_lost cleared by edge", int'(hs_lost), 0);
    check("R3", "hs relocked", int'(hs_pol_locked), 1);

    // R6/R7: fixed configuration corners
    cfg_walk = 0; cfg_composite_de = 1'b1; cfg_vde_invert = 1'b0; cfg_hde_invert = 1'b1;
    run(40);
    check("R7", "composite vde_out", int'(vde_out), 1);
    cfg_composite_de = 1'b0; cfg_timeout = '0; h_hold = 1;
    run(300);
    check("R5", "timeout disabled", int'(hs_lost), 0);

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(CLK_PER * 100000);
    if (!done) begin
      done = 1'b1;
      total++; bad++;
      $display("FAIL watchdog run did not finish actual=0 expected=1");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule